// File: doc/BRIEF.md
# Boosted Decision-Tree Ensemble Evaluator

This block scores one feature vector against a fixed-size ensemble of binary decision trees held in an on-block node store. A host first fills the node store and a small root table, one word per write, with one root address for each tree. It then presents a feature vector and pulses start. The engine captures the vector and visits the trees in index order, one node per clock. At a split node it compares one selected feature with the node threshold to pick a child. At a leaf it adds the leaf value times the leaf weight into a signed accumulator.

A tree ends when the visited node carries a leaf type flag. It is not cut off at a fixed depth. A depth guard catches malformed trees that never reach a leaf. When the last tree has ended, the engine publishes the weighted sum as the score and its sign as the classification, and pulses done. A tree that trips the guard adds nothing to the score and raises an error flag, which is held with the result.

Top module: `dt_ensemble_engine`

## Requirements
- R1: A start_i pulse while idle captures feat_i and raises busy_o on the next clock. A start_i pulse while busy_o is high is ignored and does not change the running evaluation.
- R2: A node word has these fields, from LSB up: bit 0 is the type flag (1 = split, 0 = leaf), bits [3:1] the feature index, [11:4] the unsigned threshold, [17:12] the left child address, [23:18] the right child address, [31:24] the signed leaf value, and [35:32] the unsigned leaf weight. Feature k occupies feat_i[8k+7:8k].
- R3: At a split node the engine moves to the right child when the selected feature is greater than or equal to the threshold, and otherwise to the left child. It visits exactly one node per clock.
- R4: Each tree starts at the address in its root table entry. Trees are walked in order 0 to N_TREES-1. A leaf ends its tree and adds value × weight to the running sum.
- R5: busy_o stays high for exactly as many clocks as nodes are visited over all trees. done_o is then high for one clock with busy_o low.
- R6: At done_o, score_o is the two's-complement sum of all leaf contributions, and decision_o is 1 exactly when that score is greater than or equal to zero. score_o, decision_o and err_o then hold until the next done_o.
- R7: If a split node is reached after MAX_DEPTH split nodes in the same tree, that tree ends in that clock and contributes zero. err_o is 1 at the following done_o. err_o is 0 at a later result that has no such tree.
- R8: Writes to the node store or to the root table while busy_o is high are ignored.
- R9: After reset, busy_o, done_o, score_o, decision_o and err_o are 0. Every node word and root entry is 0, so every tree is a single zero leaf at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_we_i | input | 1 | Node store write enable |
| node_addr_i | input | ADDR_W (6) | Node store write address |
| node_data_i | input | NODE_W (36) | Node word to write |
| root_we_i | input | 1 | Root table write enable |
| root_sel_i | input | TIDX_W (2) | Tree index of the root entry |
| root_addr_i | input | ADDR_W (6) | Root node address for that tree |
| feat_i | input | N_FEAT*FEAT_W (64) | Packed feature vector |
| start_i | input | 1 | Begin an evaluation |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | One-clock result strobe |
| decision_o | output | 1 | 1 when the score is greater than or equal to zero |
| score_o | output | ACC_W (16) | Signed weighted leaf sum |
| err_o | output | 1 | A tree exceeded the depth limit |

## Verification
A wrong child address or a wrong comparison sense sends the walk down another path. This shows in the busy length, since paths differ in node count, and in score_o, which appears exactly at done_o. A wrong tree counter or root lookup shifts the clock of done_o. The reference model predicts busy_o and done_o clock by clock, so such faults show at the first clock where they differ. A corrupted accumulator or depth counter shows at the first done_o through score_o, decision_o or err_o. The checks then confirm that these outputs hold in the clock after done_o.

// File: rtl/dte_pkg.sv
package dte_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } dte_state_e;
endpackage

// File: rtl/dte_regfile.sv
module dte_regfile #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 36,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dte_node_step.sv
module dte_node_step #(
  parameter int N_FEAT = 8,
  parameter int FEAT_W = 8,
  parameter int ADDR_W = 6,
  parameter int VAL_W  = 8,
  parameter int WGT_W  = 4,
  localparam int FIDX_W = $clog2(N_FEAT),
  localparam int NODE_W = 1 + FIDX_W + FEAT_W + 2*ADDR_W + VAL_W + WGT_W
) (
  input  logic [NODE_W-1:0]        node_i,
  input  logic [N_FEAT*FEAT_W-1:0] feat_vec_i,
  output logic                     is_split_o,
  output logic [ADDR_W-1:0]        next_addr_o,
  output logic [VAL_W-1:0]         leaf_val_o,
  output logic [WGT_W-1:0]         leaf_wgt_o
);
  localparam int O_FIDX  = 1;
  localparam int O_THR   = O_FIDX + FIDX_W;
  localparam int O_LEFT  = O_THR + FEAT_W;
  localparam int O_RIGHT = O_LEFT + ADDR_W;
  localparam int O_VAL   = O_RIGHT + ADDR_W;
  localparam int O_WGT   = O_VAL + VAL_W;

  logic [FEAT_W-1:0] feats [N_FEAT];
  for (genvar g = 0; g < N_FEAT; g++) begin : g_unpack
    assign feats[g] = feat_vec_i[g*FEAT_W +: FEAT_W];
  end

  logic [FIDX_W-1:0] fidx;
  logic [FEAT_W-1:0] thr;
  logic              go_right;

  assign fidx        = node_i[O_FIDX +: FIDX_W];
  assign thr         = node_i[O_THR +: FEAT_W];
  assign go_right    = (feats[fidx] >= thr);
  assign is_split_o  = node_i[0];
  assign next_addr_o = go_right ? node_i[O_RIGHT +: ADDR_W] : node_i[O_LEFT +: ADDR_W];
  assign leaf_val_o  = node_i[O_VAL +: VAL_W];
  assign leaf_wgt_o  = node_i[O_WGT +: WGT_W];
endmodule

// File: rtl/dte_weight_acc.sv
module dte_weight_acc #(
  parameter int VAL_W = 8,
  parameter int WGT_W = 4,
  parameter int ACC_W = 16,
  localparam int PROD_W = VAL_W + WGT_W + 1
) (
  input  logic             add_en_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [VAL_W-1:0] val_i,
  input  logic [WGT_W-1:0] wgt_i,
  output logic [ACC_W-1:0] sum_o
);
  logic signed [PROD_W-1:0] val_s, wgt_s, prod;
  logic        [ACC_W-1:0]  prod_ext;

  assign val_s    = PROD_W'($signed(val_i));
  assign wgt_s    = PROD_W'($signed({1'b0, wgt_i}));
  assign prod     = val_s * wgt_s;
  assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  assign sum_o    = add_en_i ? (acc_i + prod_ext) : acc_i;
endmodule

// File: rtl/dt_ensemble_engine.sv
module dt_ensemble_engine #(
  parameter int N_FEAT    = 8,
  parameter int FEAT_W    = 8,
  parameter int ADDR_W    = 6,
  parameter int VAL_W     = 8,
  parameter int WGT_W     = 4,
  parameter int N_TREES   = 4,
  parameter int MAX_DEPTH = 8,
  localparam int FIDX_W  = $clog2(N_FEAT),
  localparam int NODE_W  = 1 + FIDX_W + FEAT_W + 2*ADDR_W + VAL_W + WGT_W,
  localparam int N_NODES = 1 << ADDR_W,
  localparam int TIDX_W  = (N_TREES > 1) ? $clog2(N_TREES) : 1,
  localparam int DEPTH_W = $clog2(MAX_DEPTH + 1),
  localparam int ACC_W   = VAL_W + WGT_W + 1 + TIDX_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     node_we_i,
  input  logic [ADDR_W-1:0]        node_addr_i,
  input  logic [NODE_W-1:0]        node_data_i,
  input  logic                     root_we_i,
  input  logic [TIDX_W-1:0]        root_sel_i,
  input  logic [ADDR_W-1:0]        root_addr_i,
  input  logic [N_FEAT*FEAT_W-1:0] feat_i,
  input  logic                     start_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     decision_o,
  output logic [ACC_W-1:0]         score_o,
  output logic                     err_o
);
  import dte_pkg::*;

  dte_state_e               state_q;
  logic [N_FEAT*FEAT_W-1:0] feat_q;
  logic [TIDX_W-1:0]        tree_q;
  logic [ADDR_W-1:0]        addr_q;
  logic [DEPTH_W-1:0]       depth_q;
  logic [ACC_W-1:0]         acc_q, score_q;
  logic                     err_run_q, err_q, dec_q, done_q;

  logic                     busy;
  logic [NODE_W-1:0]        node;
  logic [TIDX_W-1:0]        root_raddr;
  logic [ADDR_W-1:0]        root_addr;
  logic                     is_split;
  logic [ADDR_W-1:0]        next_addr;
  logic [VAL_W-1:0]         leaf_val;
  logic [WGT_W-1:0]         leaf_wgt;
  logic [ACC_W-1:0]         sum;
  logic                     overrun, tree_end, last_tree;

  assign busy = (state_q == ST_WALK);

  dte_regfile #(.DEPTH(N_NODES), .WIDTH(NODE_W)) u_nodes (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (node_we_i && !busy),
    .waddr_i (node_addr_i),
    .wdata_i (node_data_i),
    .raddr_i (addr_q),
    .rdata_o (node)
  );

  // idle: root of tree 0 for start; walking: root of the following tree
  assign root_raddr = busy ? (tree_q + 1'b1) : '0;

  dte_regfile #(.DEPTH(N_TREES), .WIDTH(ADDR_W)) u_roots (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (root_we_i && !busy),
    .waddr_i (root_sel_i),
    .wdata_i (root_addr_i),
    .raddr_i (root_raddr),
    .rdata_o (root_addr)
  );

  dte_node_step #(
    .N_FEAT(N_FEAT), .FEAT_W(FEAT_W), .ADDR_W(ADDR_W),
    .VAL_W(VAL_W), .WGT_W(WGT_W)
  ) u_step (
    .node_i      (node),
    .feat_vec_i  (feat_q),
    .is_split_o  (is_split),
    .next_addr_o (next_addr),
    .leaf_val_o  (leaf_val),
    .leaf_wgt_o  (leaf_wgt)
  );

  dte_weight_acc #(.VAL_W(VAL_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_acc (
    .add_en_i (!is_split),
    .acc_i    (acc_q),
    .val_i    (leaf_val),
    .wgt_i    (leaf_wgt),
    .sum_o    (sum)
  );

  assign overrun   = is_split && (depth_q == DEPTH_W'(MAX_DEPTH));
  assign tree_end  = !is_split || overrun;
  assign last_tree = (tree_q == TIDX_W'(N_TREES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      feat_q    <= '0;
      tree_q    <= '0;
      addr_q    <= '0;
      depth_q   <= '0;
      acc_q     <= '0;
      score_q   <= '0;
      err_run_q <= 1'b0;
      err_q     <= 1'b0;
      dec_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q   <= ST_WALK;
            feat_q    <= feat_i;
            tree_q    <= '0;
            addr_q    <= root_addr;
            depth_q   <= '0;
            acc_q     <= '0;
            err_run_q <= 1'b0;
          end
        end
        ST_WALK: begin
          if (tree_end) begin
            acc_q     <= sum;
            err_run_q <= err_run_q | overrun;
            depth_q   <= '0;
            if (last_tree) begin
              state_q <= ST_IDLE;
              score_q <= sum;
              dec_q   <= !sum[ACC_W-1];
              err_q   <= err_run_q | overrun;
              done_q  <= 1'b1;
            end else begin
              tree_q <= tree_q + 1'b1;
              addr_q <= root_addr;
            end
          end else begin
            addr_q  <= next_addr;
            depth_q <= depth_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = busy;
  assign done_o     = done_q;
  assign decision_o = dec_q;
  assign score_o    = score_q;
  assign err_o      = err_q;
endmodule

// File: rtl/dte_checker.sv
module dte_checker #(
  parameter int MAX_DEPTH = 8,
  parameter int DEPTH_W   = 4,
  parameter int ACC_W     = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               decision_o,
  input logic [ACC_W-1:0]   score_o,
  input logic               err_o,
  input logic [DEPTH_W-1:0] depth_i
);
  a_r1_busy_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r5_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r6_score_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(score_o));

  a_r6_decision_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (decision_o == ($signed(score_o) >= 0)));

  a_r7_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(err_o));

  a_r7_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_i <= DEPTH_W'(MAX_DEPTH));
endmodule

bind dt_ensemble_engine dte_checker #(
  .MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W), .ACC_W(ACC_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .decision_o (decision_o),
  .score_o    (score_o),
  .err_o      (err_o),
  .depth_i    (depth_q)
);

// File: tb/sim_dt_ensemble_engine.sv
module sim_dt_ensemble_engine;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        node_we = 1'b0, root_we = 1'b0, start = 1'b0;
  logic [5:0]  node_addr = '0, root_addr = '0;
  logic [35:0] node_data = '0;
  logic [1:0]  root_sel = '0;
  logic [63:0] feat = '0;
  logic        busy, done, decision, err;
  logic [15:0] score;

  int checks = 0, errors = 0;
  logic [35:0] mem_m [64];
  logic [5:0]  root_m [4];

  always #10 clk = ~clk;

  dt_ensemble_engine u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .node_we_i(node_we), .node_addr_i(node_addr), .node_data_i(node_data),
    .root_we_i(root_we), .root_sel_i(root_sel), .root_addr_i(root_addr),
    .feat_i(feat), .start_i(start),
    .busy_o(busy), .done_o(done), .decision_o(decision), .score_o(score), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [35:0] mk_split(int f, int thr, int l, int r);
    return {4'd0, 8'd0, 6'(r), 6'(l), 8'(thr), 3'(f), 1'b1};
  endfunction

  function automatic logic [35:0] mk_leaf(int v, int w);
    return {4'(w), 8'(v), 6'd0, 6'd0, 8'd0, 3'd0, 1'b0};
  endfunction

  task automatic put_node(input int a, input logic [35:0] d);
    @(negedge clk);
    node_we = 1'b1; node_addr = 6'(a); node_data = d;
    @(negedge clk);
    node_we = 1'b0;
    mem_m[a] = d;
  endtask

  task automatic put_root(input int t, input int a);
    @(negedge clk);
    root_we = 1'b1; root_sel = 2'(t); root_addr = 6'(a);
    @(negedge clk);
    root_we = 1'b0;
    root_m[t] = 6'(a);
  endtask

  // behavioural walk: score, error, node visits
  task automatic model(input logic [63:0] fv, output int sc, output bit er, output int cyc);
    sc = 0; er = 0; cyc = 0;
    for (int t = 0; t < 4; t++) begin
      int a = root_m[t];
      int d = 0;
      while (1) begin
        logic [35:0] n = mem_m[a];
        cyc++;
        if (!n[0]) begin
          int v = $signed(n[31:24]);
          int w = n[35:32];
          sc += v * w;
          break;
        end
        if (d == 8) begin er = 1; break; end
        if (fv[n[3:1]*8 +: 8] >= n[11:4]) a = n[23:18]; else a = n[17:12];
        d++;
      end
    end
  endtask

  task automatic run(input logic [63:0] fv, input string req, input bit poke_start, input bit poke_load);
    int sc, cyc; bit er;
    logic [5:0] keep_addr;
    model(fv, sc, er, cyc);
    keep_addr = root_m[0];
    @(negedge clk);
    feat = fv; start = 1'b1;
    for (int k = 1; k <= cyc; k++) begin
      @(negedge clk);
      start = 1'b0; node_we = 1'b0;
      if (poke_load && k == 2) begin
        node_we = 1'b1; node_addr = keep_addr; node_data = mk_leaf(99, 15);
      end
      if (poke_start && k == 3) begin
        start = 1'b1; feat = ~fv;
      end
      chk(busy === 1'b1 && done === 1'b0, req, "busy during walk", int'(busy), 1);
    end
    @(negedge clk);
    start = 1'b0; node_we = 1'b0;
    chk(done === 1'b1 && busy === 1'b0, "R5", "done strobe", int'(done), 1);
    chk($signed(score) == sc, req, "score", $signed(score), sc);
    chk(decision === (sc >= 0), "R6", "decision", int'(decision), int'(sc >= 0));
    chk(err === er, "R7", "err flag", int'(err), int'(er));
    @(negedge clk);
    chk(done === 1'b0 && $signed(score) == sc && err === er, "R6", "result held", $signed(score), sc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem_m[i] = '0;
    for (int i = 0; i < 4; i++) root_m[i] = '0;
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && score === 0 && decision === 0 && err === 0,
        "R9", "reset outputs", int'(score), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy === 0 && done === 0, "R9", "idle after reset", int'(busy), 0);
    run(64'h0102030405060708, "R9", 0, 0);

    // R2 node layout, R4 roots
    put_node(0,  mk_split(0, 100, 1, 2));
    put_node(1,  mk_split(1, 50, 3, 4));
    put_node(2,  mk_leaf(20, 3));
    put_node(3,  mk_leaf(-10, 2));
    put_node(4,  mk_leaf(5, 1));
    put_node(10, mk_leaf(-7, 4));
    put_node(20, mk_split(2, 30, 21, 22));
    put_node(21, mk_split(3, 200, 23, 24));
    put_node(22, mk_leaf(9, 5));
    put_node(23, mk_split(4, 1, 25, 26));
    put_node(24, mk_leaf(-3, 7));
    put_node(25, mk_leaf(-128, 15));
    put_node(26, mk_leaf(127, 15));
    put_node(30, mk_split(7, 255, 31, 32));
    put_node(31, mk_leaf(-1, 1));
    put_node(32, mk_leaf(100, 2));
    put_root(0, 0); put_root(1, 10); put_root(2, 20); put_root(3, 30);

    run(64'h0, "R4", 0, 0);
    run(64'hFF00_0000_C81E_3264, "R3", 0, 0);   // features equal to thresholds
    run(64'hFFFF_FFFF_FFFF_FFFF, "R2", 0, 0);
    run(64'h0000_0001_C71D_3163, "R3", 0, 0);   // one below thresholds
    run(64'h0000_0000_0000_6400, "R1", 1, 0);
    run(64'h0000_0000_0000_6400, "R8", 0, 1);
    run(64'h0000_0000_0000_6400, "R8", 0, 0);

    // R7 self-looping tree
    put_node(40, mk_split(0, 0, 40, 40));
    put_root(1, 40);
    run(64'h0, "R7", 0, 0);
    put_root(1, 10);
    run(64'h0, "R7", 0, 0);

    // R7 exactly MAX_DEPTH splits is legal
    for (int i = 48; i < 56; i++) put_node(i, mk_split(0, 0, i + 1, i + 1));
    put_node(56, mk_leaf(1, 1));
    put_root(3, 48);
    run(64'h5, "R7", 0, 0);

    // R6 zero and negative scores
    put_node(60, mk_leaf(0, 9));
    put_node(61, mk_leaf(-1, 1));
    for (int t = 0; t < 4; t++) put_root(t, 60);
    run(64'h0, "R6", 0, 0);
    for (int t = 0; t < 4; t++) put_root(t, 61);
    run(64'h0, "R6", 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule